// File: doc/BRIEF.md
# Edge-Cleared Processor Watchdog with Repeating Fault Pulse

This block supervises a processor by watching a heartbeat line that software is expected to toggle. A timeout counter starts from zero at every clearing event and counts clock cycles. A clearing event is any change of the heartbeat level, in either direction, or a system reset request. If the counter reaches its limit, the block drives an active-low fault output. The fault output then repeats a short low pulse at a fixed interval until the heartbeat changes again. A heartbeat change ends any pulse that is in progress. All of these intervals are parameters in clock cycles.

A supply-undervoltage flag overrides the timer. While the flag is set, the fault output is held low through a combinational path, and it returns high in the same cycle the flag clears, with no minimum low time. The flag also holds the counter cleared. A disable input stands for a heartbeat line that is left floating or high-impedance. While it is set, the timer is held cleared and no timeout can happen, so the fault output depends on the supply flag alone.

The heartbeat passes through a synchronizer of `SYNC_STAGES` flops. An edge is found by comparing the last synchronizer stage with its previous value.

Top module: `hb_watchdog`

## Requirements
- R1: While `rst_ni` is low and `vlow_i` is low, `fault_no` is 1. Releasing reset leaves the counter at zero.
- R2: A "clearing edge" is a rising clock edge at which a clear condition is sampled. `fault_no` goes low TIMEOUT_CYC rising edges after the last clearing edge, and stays high at the edge before that.
- R3: A heartbeat change from 0 to 1 is a clear condition, and so is a change from 1 to 0. A change made between two clock edges is sampled as a clear at the (SYNC_STAGES+1)-th rising edge after it.
- R4: A heartbeat level held for a single clock period produces two clears, and the timeout is measured from the second one.
- R5: Once timed out, `fault_no` is low for PULSE_CYC cycles and high for the rest of each PERIOD_CYC-cycle interval. This repeats until a clear condition occurs.
- R6: A heartbeat change during a fault pulse returns `fault_no` to 1 at the clearing edge of that change.
- R7: `sys_rst_i` = 1 at a rising edge is a clear condition and ends any fault pulse.
- R8: `vlow_i` = 1 forces `fault_no` to 0 in the same cycle, with no clock edge needed. It is also a clear condition.
- R9: When `vlow_i` returns to 0 and no fault pulse is active, `fault_no` returns to 1 in the same cycle.
- R10: While `wd_off_i` = 1 no timeout occurs, and `fault_no` follows only `vlow_i`. `wd_off_i` = 1 is a clear condition, so the timer starts from zero after it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hb_i | input | 1 | Heartbeat from the processor, asynchronous, either edge services the timer |
| wd_off_i | input | 1 | Watchdog disable (heartbeat line floating) |
| sys_rst_i | input | 1 | Synchronous system or manual reset request, clears the timer |
| vlow_i | input | 1 | Supply undervoltage flag, 1 = below threshold |
| fault_no | output | 1 | Watchdog fault output, active low |

## Verification
The assertions assume that `sys_rst_i`, `vlow_i` and `wd_off_i` are synchronous to the clock. They also assume that PULSE_CYC is at least one, so the first cycle of a timeout is always low. The bench changes every input a quarter period after a rising edge, and it holds each heartbeat level for at least one full clock period. It samples the output a quarter period after an edge, or one time unit after a change of `vlow_i` when it checks the combinational override.

// File: rtl/hb_wd_pkg.sv
package hb_wd_pkg;

    typedef enum logic {
        ST_WATCH = 1'b0,
        ST_FIRE  = 1'b1
    } wd_state_e;

    function automatic int unsigned wd_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hb_sync_edge.sv
module hb_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hb_i,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } sync_s;

    sync_s sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.sync = {sy_q.sync[STAGES-2:0], hb_i};
        sy_d.last = sy_q.sync[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sy_q <= '0;
        else         sy_q <= sy_d;
    end

    assign edge_o = sy_q.sync[STAGES-1] ^ sy_q.last;

endmodule

// File: rtl/wd_timer.sv
module wd_timer
    import hb_wd_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 1600000,
    parameter int unsigned PULSE_CYC   = 220000,
    parameter int unsigned PERIOD_CYC  = 1900000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    output logic fire_o,
    output logic low_o
);
    localparam int unsigned CNT_MAX = wd_max(TIMEOUT_CYC, PERIOD_CYC);
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        wd_state_e     st;
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (clear_i) begin
            tm_d.st  = ST_WATCH;
            tm_d.cnt = '0;
        end else if (tm_q.st == ST_WATCH) begin
            if (tm_q.cnt == CW'(TIMEOUT_CYC - 1)) begin
                tm_d.st  = ST_FIRE;
                tm_d.cnt = '0;
            end else begin
                tm_d.cnt = tm_q.cnt + CW'(1);
            end
        end else begin
            if (tm_q.cnt == CW'(PERIOD_CYC - 1)) tm_d.cnt = '0;
            else                                 tm_d.cnt = tm_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tm_q <= '{st: ST_WATCH, cnt: '0};
        else         tm_q <= tm_d;
    end

    assign fire_o = (tm_q.st == ST_FIRE);
    assign low_o  = fire_o && (tm_q.cnt < CW'(PULSE_CYC));

endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned TIMEOUT_CYC = 1600000,
    parameter int unsigned PULSE_CYC   = 220000,
    parameter int unsigned PERIOD_CYC  = 1900000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hb_i,
    input  logic wd_off_i,
    input  logic sys_rst_i,
    input  logic vlow_i,
    output logic fault_no
);
    logic hb_edge;
    logic tmr_clear;
    logic fire;
    logic fire_low;

    hb_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .hb_i  (hb_i),
        .edge_o(hb_edge)
    );

    assign tmr_clear = hb_edge | sys_rst_i | vlow_i | wd_off_i;

    wd_timer #(
        .TIMEOUT_CYC(TIMEOUT_CYC),
        .PULSE_CYC  (PULSE_CYC),
        .PERIOD_CYC (PERIOD_CYC)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clear_i(tmr_clear),
        .fire_o (fire),
        .low_o  (fire_low)
    );

    assign fault_no = ~(vlow_i | fire_low);

endmodule

// File: rtl/hb_watchdog_chk.sv
module hb_watchdog_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic wd_off_i,
    input logic sys_rst_i,
    input logic vlow_i,
    input logic hb_edge,
    input logic fire,
    input logic fault_no
);
    a_r8_vlow_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vlow_i |-> !fault_no);

    a_r5_fire_starts_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fire) |-> !fault_no);

    a_r6_edge_ends_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(hb_edge) |-> !fire);

    a_r7_sysrst_ends_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(sys_rst_i) |-> !fire);

    a_r10_off_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(wd_off_i) && !vlow_i) |-> fault_no);

endmodule

bind hb_watchdog hb_watchdog_chk chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wd_off_i (wd_off_i),
    .sys_rst_i(sys_rst_i),
    .vlow_i   (vlow_i),
    .hb_edge  (hb_edge),
    .fire     (fire),
    .fault_no (fault_no)
);

// File: tb/hb_watchdog_tb_top.sv
module hb_watchdog_tb_top;
    localparam int CLK_P   = 10;
    localparam int SYNC    = 2;
    localparam int TMO     = 40;
    localparam int PULSE   = 5;
    localparam int PERIOD  = 20;
    localparam int HB_LAT  = SYNC + 1;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic hb = 1'b0;
    logic wd_off = 1'b0;
    logic sys_rst = 1'b0;
    logic vlow = 1'b0;
    logic fault_no;

    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    hb_watchdog #(
        .SYNC_STAGES(SYNC), .TIMEOUT_CYC(TMO), .PULSE_CYC(PULSE), .PERIOD_CYC(PERIOD)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .hb_i(hb), .wd_off_i(wd_off),
        .sys_rst_i(sys_rst), .vlow_i(vlow), .fault_no(fault_no)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s fault_no=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Clearing edge just passed: high until TMO-1 edges later, low at TMO.
    task automatic expect_timeout(input string req, input int already);
        step(TMO - 1 - already);
        chk(req, fault_no, 1'b1);
        step(1);
        chk(req, fault_no, 1'b0);
    endtask

    task automatic t_reset;
        step(2);
        chk("R1 in reset", fault_no, 1'b1);
        rst_ni = 1'b1;
        // release just after an edge acts like a clear at the previous edge
        expect_timeout("R1/R2 after reset", 0);
    endtask

    task automatic t_rise_timeout;
        hb = 1'b1;
        step(HB_LAT);
        chk("R3 rising clears", fault_no, 1'b1);
        expect_timeout("R2/R3 rising", 0);
    endtask

    task automatic t_repeat;
        for (int k = 1; k < PULSE; k++) begin
            step(1);
            chk("R5 pulse low", fault_no, 1'b0);
        end
        step(1);
        chk("R5 pulse end", fault_no, 1'b1);
        step(PERIOD - PULSE - 1);
        chk("R5 gap", fault_no, 1'b1);
        step(1);
        chk("R5 repeat", fault_no, 1'b0);
    endtask

    task automatic t_service_in_pulse;
        hb = 1'b0;
        step(HB_LAT - 1);
        chk("R6 still low", fault_no, 1'b0);
        step(1);
        chk("R6 released", fault_no, 1'b1);
        expect_timeout("R3 falling", 0);
    endtask

    task automatic t_short_level;
        hb = 1'b1;
        step(1);
        hb = 1'b0;
        step(HB_LAT);
        chk("R4 short level", fault_no, 1'b1);
        expect_timeout("R4 from second edge", 0);
    endtask

    task automatic t_sysrst;
        sys_rst = 1'b1;
        step(1);
        sys_rst = 1'b0;
        chk("R7 ends pulse", fault_no, 1'b1);
        expect_timeout("R7 restart", 0);
    endtask

    task automatic t_vlow;
        hb = 1'b1;
        step(HB_LAT);
        chk("R8 watching", fault_no, 1'b1);
        vlow = 1'b1;
        #1;
        chk("R8 immediate low", fault_no, 1'b0);
        step(2 * TMO);
        chk("R8 held low", fault_no, 1'b0);
        vlow = 1'b0;
        #1;
        chk("R9 immediate release", fault_no, 1'b1);
        #(CLK_P/4 - 1);
        step(0);
        expect_timeout("R8 clears timer", 0);
    endtask

    task automatic t_disable;
        int bad = 0;
        wd_off = 1'b1;
        step(1);
        chk("R10 off ends pulse", fault_no, 1'b1);
        for (int k = 0; k < 3 * TMO; k++) begin
            step(1);
            if (fault_no !== 1'b1) bad++;
        end
        checks++;
        if (bad != 0) begin
            failures++;
            $display("FAIL R10 no timeout while off: low_cycles=%0d expected=0", bad);
        end
        vlow = 1'b1;
        #1;
        chk("R10 vlow while off", fault_no, 1'b0);
        vlow = 1'b0;
        #1;
        chk("R10 vlow release while off", fault_no, 1'b1);
        step(1);
        wd_off = 1'b0;
        expect_timeout("R10 restart after enable", 0);
    endtask

    initial begin
        t_reset();
        t_rise_timeout();
        t_repeat();
        t_service_in_pulse();
        t_short_level();
        t_sysrst();
        t_vlow();
        t_disable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * CLK_P);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule